// File: doc/BRIEF.md
# Masked Montgomery Exponentiation Sequencer

This block sequences a right-to-left binary modular exponentiation over operands of up to sixteen 32-bit words. After a start pulse it reads the base one word at a time into three identical copies of the running power. It sets the running result to one. It then walks the exponent from its least significant bit upward. In every iteration it asks an external Montgomery multiplier for two products, one after the other. The first squares the power, taking its two operands from two different power copies. The second multiplies the running result by the current power.

Both outcomes of an exponent bit cause the same word writes, in the same number of cycles. The squared power is always written back into all three power copies. The two result copies are always rewritten. When the bit is set they take the fresh product. When it is clear they take a copy that was XORed with a fixed mask word one phase earlier and is unmasked on write-back. When every bit has been handled, the result is streamed out word by word and `done` pulses once.

The conversion into and out of the Montgomery domain, the modulus and the multiplier itself all sit outside this block. The multiplier is reached through a request/acknowledge port that carries full-width operands.

Top module: `mexp_seq`

## Requirements
- R1: After reset `done`, `mulReq` and `resValid` are all low.
- R2: With a multiplier that returns the product of its operands modulo N, the streamed result equals base^exponent mod N. Word 0 is the least significant word of every operand.
- R3: The first request of every iteration presents identical values on `mulOpA` and `mulOpB`, equal to the running power (the base raised to 2^k in iteration k).
- R4: The second request of every iteration presents the running result on `mulOpA` and the running power on `mulOpB`.
- R5: When the exponent bit of an iteration is 0, the running result presented in the next iteration equals the one before it, after its masked round trip through the XOR mask 0x5A5A5A5A.
- R6: Exponent bit k is taken from bit position k mod 32 of the word at `expAddr` = k div 32. Bits are processed from k = 0 up to k = len·32−1.
- R7: The number of cycles between the first requests of consecutive iterations does not depend on the exponent bit.
- R8: The result appears as `len` consecutive `resValid` cycles with `resAddr` counting 0 to len−1. `done` is high for exactly one cycle, in the cycle after the last word.
- R9: A `start` pulse while a run is in progress has no effect: there is no change of length, no second `done`, and the result is unchanged.
- R10: Operand words at index `len` and above are driven as zero on both multiplier operand buses, whatever the base source holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| lenWords | input | 5 | Operand length in 32-bit words, 1..16 |
| done | output | 1 | One-cycle completion pulse |
| baseAddr | output | 4 | Word index of the base being read |
| baseData | input | 32 | Base word at `baseAddr` |
| expAddr | output | 4 | Word index of the exponent being read |
| expData | input | 32 | Exponent word at `expAddr` |
| mulReq | output | 1 | Multiplication request, held until acknowledged |
| mulOpA | output | 512 | First multiplier operand |
| mulOpB | output | 512 | Second multiplier operand |
| mulAck | input | 1 | One-cycle acknowledge with product valid |
| mulProd | input | 512 | Product returned with `mulAck` |
| resValid | output | 1 | Result word valid |
| resAddr | output | 4 | Index of the result word |
| resData | output | 32 | Result word |

## Verification
The hardest case to reach from the ports is a clear exponent bit, where the result copies are rewritten from the masked snapshot instead of from the product. A fault there only shows up when a later set bit or the final readout uses that value. The bench therefore sweeps exponents with long runs of zero bits, including all-zero and all-one exponents, over small moduli. It follows every request with its own model of the running power and result, so a corrupted round trip is caught at the very next iteration. Runs with two-word operands and a high exponent word exercise the bit-to-word indexing, and a start pulse injected mid-run covers the ignore rule.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  // Per-cycle strobes from sequencing control to the buffer datapath
  typedef struct packed {
    logic loadWr;    // write base into power copies, one into result copies
    logic maskWr;    // snapshot masked result word
    logic capPP;     // capture squared power from multiplier
    logic capTP;     // capture result*power from multiplier
    logic updWr;     // commit one word of power and result copies
    logic opSel;     // 0: power x power, 1: result x power
    logic takeProd;  // exponent bit of the current iteration
  } seqStrobe_t;
endpackage

// File: rtl/mexp_ctrl.sv
module mexp_ctrl
  import mexp_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int LEN_W    = IDX_W + 1,
  localparam int WSH      = $clog2(WORD_W),
  localparam int BIT_W    = IDX_W + WSH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenWords,
  input  logic [WORD_W-1:0] expData,
  input  logic              mulAck,
  output logic              done,
  output logic              mulReq,
  output logic              resValid,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [IDX_W-1:0]  expAddr,
  output logic [LEN_W-1:0]  lenCur,
  output seqStrobe_t        strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_MASK, S_MUL1, S_MUL2, S_UPD, S_OUT, S_DONE
  } seqState_t;

  seqState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic             expBit;
  logic [IDX_W-1:0] lastIdx;
  logic             wordLast;
  logic             bitLast;

  assign lastIdx  = IDX_W'(lenCur - LEN_W'(1));
  assign wordLast = (wordIdx == lastIdx);
  assign bitLast  = (bitCnt == {lastIdx, {WSH{1'b1}}});
  assign expAddr  = bitCnt[BIT_W-1:WSH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      bitCnt  <= '0;
      lenCur  <= LEN_W'(1);
      expBit  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lenCur  <= lenWords;
          wordIdx <= '0;
          bitCnt  <= '0;
          state   <= S_LOAD;
        end
        S_LOAD, S_MASK, S_UPD, S_OUT: begin
          if (!wordLast) begin
            wordIdx <= wordIdx + IDX_W'(1);
          end else begin
            wordIdx <= '0;
            case (state)
              S_LOAD: state <= S_MASK;
              S_MASK: begin
                expBit <= expData[bitCnt[WSH-1:0]];
                state  <= S_MUL1;
              end
              S_UPD: begin
                if (bitLast) state <= S_OUT;
                else begin
                  bitCnt <= bitCnt + BIT_W'(1);
                  state  <= S_MASK;
                end
              end
              default: state <= S_DONE;
            endcase
          end
        end
        S_MUL1: if (mulAck) state <= S_MUL2;
        S_MUL2: if (mulAck) state <= S_UPD;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadWr   = (state == S_LOAD);
    strb.maskWr   = (state == S_MASK);
    strb.capPP    = (state == S_MUL1) && mulAck;
    strb.capTP    = (state == S_MUL2) && mulAck;
    strb.updWr    = (state == S_UPD);
    strb.opSel    = (state == S_MUL2);
    strb.takeProd = expBit;
  end

  assign mulReq   = (state == S_MUL1) || (state == S_MUL2);
  assign resValid = (state == S_OUT);
  assign done     = (state == S_DONE);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: the latched length cannot change once a run has begun
  a_r9_len_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> $stable(lenCur));
  // R7: the exponent bit is fixed through the whole write-back phase
  a_r7_bit_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UPD) && $past(state == S_UPD) |-> $stable(expBit));
endmodule

// File: rtl/mexp_dpath.sv
module mexp_dpath
  import mexp_pkg::*;
#(
  parameter int MAX_WORDS            = 16,
  parameter int WORD_W               = 32,
  parameter logic [WORD_W-1:0] MASK_WORD = 32'h5A5A5A5A,
  localparam int IDX_W               = $clog2(MAX_WORDS),
  localparam int LEN_W               = IDX_W + 1,
  localparam int BUS_W               = MAX_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [LEN_W-1:0]  lenCur,
  input  logic [WORD_W-1:0] baseData,
  input  logic [BUS_W-1:0]  mulProd,
  output logic [BUS_W-1:0]  mulOpA,
  output logic [BUS_W-1:0]  mulOpB,
  output logic [WORD_W-1:0] resData
);
  // three power copies, two result copies, masked snapshot, products
  logic [WORD_W-1:0] pw1 [MAX_WORDS];
  logic [WORD_W-1:0] pw2 [MAX_WORDS];
  logic [WORD_W-1:0] pw3 [MAX_WORDS];
  logic [WORD_W-1:0] rs1 [MAX_WORDS];
  logic [WORD_W-1:0] rs2 [MAX_WORDS];
  logic [WORD_W-1:0] snap [MAX_WORDS];
  logic [WORD_W-1:0] sqProd [MAX_WORDS];
  logic [WORD_W-1:0] rsProd [MAX_WORDS];

  always_ff @(posedge clk) begin
    if (strb.loadWr) begin
      pw1[wordIdx] <= baseData;
      pw2[wordIdx] <= baseData;
      pw3[wordIdx] <= baseData;
      rs1[wordIdx] <= (wordIdx == '0) ? WORD_W'(1) : '0;
      rs2[wordIdx] <= (wordIdx == '0) ? WORD_W'(1) : '0;
    end
    if (strb.maskWr) snap[wordIdx] <= rs1[wordIdx] ^ MASK_WORD;
    for (int w = 0; w < MAX_WORDS; w++) begin
      if (strb.capPP) sqProd[w] <= mulProd[w*WORD_W +: WORD_W];
      if (strb.capTP) rsProd[w] <= mulProd[w*WORD_W +: WORD_W];
    end
    if (strb.updWr) begin
      pw1[wordIdx] <= sqProd[wordIdx];
      pw2[wordIdx] <= sqProd[wordIdx];
      pw3[wordIdx] <= sqProd[wordIdx];
      rs1[wordIdx] <= strb.takeProd ? rsProd[wordIdx] : snap[wordIdx] ^ MASK_WORD;
      rs2[wordIdx] <= strb.takeProd ? rsProd[wordIdx] : snap[wordIdx] ^ MASK_WORD;
    end
  end

  // Operand buses: squaring reads two separate copies; words beyond len are zero
  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_opBus
    logic inRange;
    assign inRange = (LEN_W'(g) < lenCur);
    assign mulOpA[g*WORD_W +: WORD_W] = !inRange ? '0 : (strb.opSel ? rs2[g] : pw1[g]);
    assign mulOpB[g*WORD_W +: WORD_W] = !inRange ? '0 : (strb.opSel ? pw3[g] : pw2[g]);
  end

  assign resData = rs1[wordIdx];

  // R3: the power copies agree after each committed word
  a_r3_power_copies: assert property (@(posedge clk) disable iff (!rstN)
    strb.updWr |=> (pw1[$past(wordIdx)] == pw2[$past(wordIdx)]) &&
                   (pw2[$past(wordIdx)] == pw3[$past(wordIdx)]));
  // R4: the result copies agree after each committed word
  a_r4_result_copies: assert property (@(posedge clk) disable iff (!rstN)
    strb.updWr |=> rs1[$past(wordIdx)] == rs2[$past(wordIdx)]);
  // R5: a clear bit restores the prior result word through the mask
  a_r5_unmask_restores: assert property (@(posedge clk) disable iff (!rstN)
    strb.updWr && !strb.takeProd |=> rs1[$past(wordIdx)] == $past(rs1[wordIdx]));
endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int MAX_WORDS                = 16,
  parameter int WORD_W                   = 32,
  parameter logic [WORD_W-1:0] MASK_WORD = 32'h5A5A5A5A,
  localparam int IDX_W                   = $clog2(MAX_WORDS),
  localparam int LEN_W                   = IDX_W + 1,
  localparam int BUS_W                   = MAX_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenWords,
  output logic              done,
  output logic [IDX_W-1:0]  baseAddr,
  input  logic [WORD_W-1:0] baseData,
  output logic [IDX_W-1:0]  expAddr,
  input  logic [WORD_W-1:0] expData,
  output logic              mulReq,
  output logic [BUS_W-1:0]  mulOpA,
  output logic [BUS_W-1:0]  mulOpB,
  input  logic              mulAck,
  input  logic [BUS_W-1:0]  mulProd,
  output logic              resValid,
  output logic [IDX_W-1:0]  resAddr,
  output logic [WORD_W-1:0] resData
);
  seqStrobe_t       strb;
  logic [IDX_W-1:0] wordIdx;
  logic [LEN_W-1:0] lenCur;

  mexp_ctrl #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenWords(lenWords),
    .expData(expData), .mulAck(mulAck), .done(done), .mulReq(mulReq),
    .resValid(resValid), .wordIdx(wordIdx), .expAddr(expAddr),
    .lenCur(lenCur), .strb(strb)
  );

  mexp_dpath #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W), .MASK_WORD(MASK_WORD)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx), .lenCur(lenCur),
    .baseData(baseData), .mulProd(mulProd), .mulOpA(mulOpA), .mulOpB(mulOpB),
    .resData(resData)
  );

  assign baseAddr = wordIdx;
  assign resAddr  = wordIdx;
endmodule

// File: tb/mexp_seq_test.sv
module mexp_seq_test;
  localparam int MW = 16;
  localparam int WW = 32;
  localparam int BW = MW * WW;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    lenWords = 5'd1;
  logic          done, mulReq, resValid;
  logic [3:0]    baseAddr, expAddr, resAddr;
  logic [WW-1:0] baseData, expData, resData;
  logic [BW-1:0] mulOpA, mulOpB;
  logic          mulAck = 1'b0;
  logic [BW-1:0] mulProd = '0;

  logic [WW-1:0] baseMem [MW];
  logic [WW-1:0] expMem  [MW];

  assign baseData = baseMem[baseAddr];
  assign expData  = expMem[expAddr];

  mexp_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .lenWords(lenWords), .done(done),
    .baseAddr(baseAddr), .baseData(baseData), .expAddr(expAddr), .expData(expData),
    .mulReq(mulReq), .mulOpA(mulOpA), .mulOpB(mulOpB), .mulAck(mulAck),
    .mulProd(mulProd), .resValid(resValid), .resAddr(resAddr), .resData(resData)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // run context shared with the negedge monitor
  longint unsigned modN, refR, refP, resVal;
  int  runLen, kIdx, parity, resCnt, doneCnt, lastSq, ivRef;
  bit  prevZero, lastWasRes, mBusy;
  int  mCnt;
  longint unsigned mProd;

  function automatic bit expBitAt(int k);
    return expMem[k / 32][k % 32];
  endfunction

  function automatic longint unsigned refPow(longint unsigned n, longint unsigned a, int len);
    longint unsigned r = 1, p = a;
    for (int k = 0; k < len * 32; k++) begin
      if (expBitAt(k)) r = (r * p) % n;
      p = (p * p) % n;
    end
    return r;
  endfunction

  // behavioural multiplier plus request and result monitor
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      mulAck = 1'b0;
      mBusy  = 1'b0;
    end else begin
      if (mulAck) mulAck = 1'b0;
      else if (mBusy) begin
        if (mCnt == 0) begin
          mulProd = BW'(mProd);
          mulAck  = 1'b1;
          mBusy   = 1'b0;
        end else mCnt--;
      end else if (mulReq) begin
        if (runLen < MW) begin
          check((mulOpA >> (runLen * 32)) == '0, "R10 opA upper", 0, 0);
          check((mulOpB >> (runLen * 32)) == '0, "R10 opB upper", 0, 0);
        end
        if (parity == 0) begin
          check(mulOpA == mulOpB, "R3 square operands equal", mulOpA[63:0], mulOpB[63:0]);
          check(mulOpA[63:0] == refP, "R3 power", mulOpA[63:0], refP);
          if (lastSq >= 0) begin
            if (ivRef == 0) ivRef = cyc - lastSq;
            else check((cyc - lastSq) == ivRef, "R7 iteration length",
                       longint'(cyc - lastSq), longint'(ivRef));
          end
          lastSq = cyc;
        end else begin
          check(mulOpA[63:0] == refR, prevZero ? "R5 result kept" : "R4 result",
                mulOpA[63:0], refR);
          check(mulOpB[63:0] == refP, "R4 power", mulOpB[63:0], refP);
          if (expBitAt(kIdx)) refR = (refR * refP) % modN;
          prevZero = !expBitAt(kIdx);
          refP = (refP * refP) % modN;
          kIdx++;
        end
        mProd  = (longint'(mulOpA[63:0]) * longint'(mulOpB[63:0])) % modN;
        parity = 1 - parity;
        mBusy  = 1'b1;
        mCnt   = LAT;
      end
      if (done) begin
        check(lastWasRes && resCnt == runLen, "R8 done after last word",
              longint'(resCnt), longint'(runLen));
        doneCnt++;
      end
      if (resValid) begin
        check(resAddr == 4'(resCnt), "R8 word order", resAddr, resCnt);
        if (resCnt < 2) resVal |= longint'(resData) << (32 * resCnt);
        else check(resData == 0, "R2 high result word", resData, 0);
        resCnt++;
      end
      lastWasRes = resValid;
    end
  end

  task automatic runExp(input int len, input longint unsigned n, input longint unsigned a,
                        input logic [31:0] e0, input logic [31:0] e1, input bit midStart);
    longint unsigned want;
    int guard = 0;
    for (int i = 0; i < MW; i++) begin
      baseMem[i] = (i < len) ? '0 : 32'hC3A5_0F1E + i;
      expMem[i]  = '0;
    end
    baseMem[0] = 32'(a);
    expMem[0]  = e0;
    if (len > 1) expMem[1] = e1;
    modN = n; runLen = len; refR = 1; refP = a; kIdx = 0; parity = 0;
    resVal = 0; resCnt = 0; doneCnt = 0; lastSq = -1; ivRef = 0; prevZero = 0;
    @(negedge clk);
    lenWords = 5'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneCnt == 0 && guard < 20000) begin
      @(posedge clk);
      guard++;
      if (midStart && guard == 40) begin
        @(negedge clk);
        lenWords = 5'(len + 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    repeat (6) @(posedge clk);
    want = refPow(n, a, len);
    check(doneCnt == 1, midStart ? "R9 single done" : "R8 single done", doneCnt, 1);
    check(resVal == want, (len > 1) ? "R2 R6 result" : "R2 result", resVal, want);
    check(kIdx == len * 32, "R6 bit count", kIdx, len * 32);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint unsigned mods [3] = '{61, 251, 4093};
    for (int i = 0; i < MW; i++) begin baseMem[i] = '0; expMem[i] = '0; end
    repeat (3) @(negedge clk);
    check(!done && !mulReq && !resValid, "R1 reset outputs", {done, mulReq, resValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !mulReq && !resValid, "R1 idle outputs", {done, mulReq, resValid}, 0);
    // sweep over moduli, bases and exponent patterns (single word)
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 4; b++) begin
        longint unsigned a = (b == 0) ? 1 : (b == 1) ? mods[m] - 1 : (b * 37 + m * 11) % mods[m];
        logic [31:0] e = 32'h9E37_79B9 * (m * 4 + b + 1);
        runExp(1, mods[m], a, e, 0, 0);
      end
    end
    runExp(1, 251, 7, 32'h0000_0000, 0, 0);   // all bits clear: result one
    runExp(1, 251, 0, 32'h0000_0005, 0, 0);   // zero base
    runExp(1, 4093, 1234, 32'hFFFF_FFFF, 0, 0);
    runExp(1, 4093, 999, 32'h8000_0000, 0, 0);  // only the top bit
    // two-word operands: high exponent word selects bits 32..63
    runExp(2, 251, 3, 32'h0000_0000, 32'h0000_0001, 0);
    runExp(2, 4093, 2001, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    runExp(2, 61, 17, 32'h0000_0001, 32'h8000_0000, 0);
    // start during a run is ignored
    runExp(1, 4093, 321, 32'hA5A5_0F0F, 0, 1);
    runExp(2, 251, 99, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule